// File: doc/BRIEF.md
# Multicycle 32-bit Integer Core

This block is a small, non-pipelined 32-bit processor. A single state machine walks every instruction through a fixed set of one-clock steps: fetch, decode, execute, an optional memory step and an optional writeback. Internal registers hold the state between steps. An instruction register and two operand latches are filled during decode. A result latch, a data address latch and a store data latch are filled during execute. Results go back to a 32-entry register file.

Instruction and data memories sit outside the core. Both are synchronous and word-addressed, and each returns the addressed word one clock after the address is presented. The program counter holds an instruction index and steps by one per instruction.

The core supports:
- arithmetic and logic on registers and on a sign-extended 16-bit immediate
- logical shifts by one bit
- signed set-on-compare against an immediate
- word loads and stores
- branches on a zero or non-zero register
- register jumps, with and without a link
- a no-op and a terminal halt

Once halted, the core raises `halted` and stays there until reset.

Top module: `mcyc_core`

## Requirements
- R1: Register 0 always reads as zero, and a writeback that targets register 0 changes nothing.
- R2: The register file is never read and written in the same clock. Reads happen only in the decode step and writes only in the writeback step.
- R3: Immediate format: opcode[31:26], source[25:21], destination[20:16], immediate[15:0]. Register format: opcode[31:26]=0, source A[25:21], source B[20:16], destination[15:11], an ignored field [10:6], function[5:0]. Register functions: add 0x20, sub 0x22, and 0x24, or 0x25, xor 0x26. The add-immediate opcode 0x08 computes source + sext(imm). All arithmetic wraps modulo 2^32.
- R4: Register-format function 0x00 shifts source A left by one bit, and function 0x02 shifts it right by one bit, filling with zero.
- R5: Compare-immediate opcodes are 0x18 (<), 0x19 (==), 0x1A (>), 0x1B (<=), 0x1C (>=) and 0x1D (!=). Each writes 1 to the destination if source compares true against sext(imm), treating both as signed, and writes 0 otherwise.
- R6: Load (opcode 0x23) writes the destination with the data word at source + sext(imm). Store (opcode 0x2B) writes the register named in bits [20:16] to that word address. The data write strobe is high only during a store's memory step.
- R7: Branch-if-zero (0x04) and branch-if-nonzero (0x05) test the source register. When the test holds, the next PC is PC + 1 + sext(imm); otherwise it is PC + 1.
- R8: Jump-register (0x12) sets PC to the source value. Jump-and-link (0x13) writes PC + 1 into register 31 and sets PC to the source value.
- R9: The no-op opcode (0x3E), and any opcode or function not listed above, change no register or memory. Halt (0x3F) enters a state the core never leaves: `halted` stays high, the fetch address stays fixed and no further store occurs.
- R10: The PC is an instruction index that advances by one per instruction. It changes only at the end of the decode and execute steps. A loop that sums 0 through 100 leaves 5050.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Instruction word index (the PC) |
| imem_rdata | input | 32 | Instruction word, valid one clock after the address |
| dmem_addr | output | 32 | Data word address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data write strobe |
| dmem_rdata | input | 32 | Load data, valid one clock after the address |
| halted | output | 1 | High while the core sits in its halt state |

## Verification
The in-module assertions check on every cycle that:
- read and write of the register file never overlap;
- a register-0 source always latches zero;
- the PC moves only at the end of decode or execute;
- the data write strobe only ever comes from a store;
- the halt state is never left.

The arithmetic, shift, compare, load and branch results, and the link value and jump targets, can only be shown by the bench's programs. Each program stores its registers to data memory, and the bench compares those words with values it works out itself. The summing loop checks that branching and writeback work together over many iterations.

// File: rtl/mcyc_pkg.sv
// Package mcyc_pkg
// Shared constants and types for the multicycle core: data width,
// instruction encodings, controller states, instruction classes and
// ALU operations, plus the decode helpers used by the datapath.
// Assumes 32-bit instructions in the two formats described in the brief.
package mcyc_pkg;

    localparam int XLEN = 32;

    // Primary opcodes
    localparam logic [5:0] OP_REG  = 6'h00;
    localparam logic [5:0] OP_BEQZ = 6'h04;
    localparam logic [5:0] OP_BNEZ = 6'h05;
    localparam logic [5:0] OP_ADDI = 6'h08;
    localparam logic [5:0] OP_JR   = 6'h12;
    localparam logic [5:0] OP_JALR = 6'h13;
    localparam logic [5:0] OP_SLTI = 6'h18;
    localparam logic [5:0] OP_SEQI = 6'h19;
    localparam logic [5:0] OP_SGTI = 6'h1A;
    localparam logic [5:0] OP_SLEI = 6'h1B;
    localparam logic [5:0] OP_SGEI = 6'h1C;
    localparam logic [5:0] OP_SNEI = 6'h1D;
    localparam logic [5:0] OP_LW   = 6'h23;
    localparam logic [5:0] OP_SW   = 6'h2B;
    localparam logic [5:0] OP_NOP  = 6'h3E;
    localparam logic [5:0] OP_HALT = 6'h3F;

    // Register-format function codes
    localparam logic [5:0] FN_SLLI = 6'h00;
    localparam logic [5:0] FN_SRLI = 6'h02;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;

    typedef enum logic [2:0] {
        ST_INIT, ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB, ST_HALT
    } state_e;

    typedef enum logic [3:0] {
        CL_ALU_R, CL_ALU_I, CL_LOAD, CL_STORE, CL_BRZ,
        CL_JR, CL_JALR, CL_NOP, CL_HALT
    } cls_e;

    typedef enum logic [3:0] {
        AL_ADD, AL_SUB, AL_AND, AL_OR, AL_XOR, AL_SHL1, AL_SHR1,
        AL_LT, AL_EQ, AL_GT, AL_LE, AL_GE, AL_NE
    } alu_e;

    // Map a fetched word onto the class that steers the controller.
    function automatic cls_e classify(input logic [XLEN-1:0] ir);
        cls_e c;
        case (ir[31:26])
            OP_REG: begin
                case (ir[5:0])
                    FN_SLLI, FN_SRLI, FN_ADD, FN_SUB,
                    FN_AND, FN_OR, FN_XOR: c = CL_ALU_R;
                    default:               c = CL_NOP;
                endcase
            end
            OP_ADDI, OP_SLTI, OP_SEQI, OP_SGTI,
            OP_SLEI, OP_SGEI, OP_SNEI: c = CL_ALU_I;
            OP_LW:                     c = CL_LOAD;
            OP_SW:                     c = CL_STORE;
            OP_BEQZ, OP_BNEZ:          c = CL_BRZ;
            OP_JR:                     c = CL_JR;
            OP_JALR:                   c = CL_JALR;
            OP_HALT:                   c = CL_HALT;
            default:                   c = CL_NOP;
        endcase
        return c;
    endfunction

    // Pick the ALU operation for a word of class CL_ALU_R or CL_ALU_I.
    function automatic alu_e alu_of(input logic [XLEN-1:0] ir);
        alu_e a;
        if (ir[31:26] == OP_REG) begin
            case (ir[5:0])
                FN_SLLI: a = AL_SHL1;
                FN_SRLI: a = AL_SHR1;
                FN_SUB:  a = AL_SUB;
                FN_AND:  a = AL_AND;
                FN_OR:   a = AL_OR;
                FN_XOR:  a = AL_XOR;
                default: a = AL_ADD;
            endcase
        end else begin
            case (ir[31:26])
                OP_SLTI: a = AL_LT;
                OP_SEQI: a = AL_EQ;
                OP_SGTI: a = AL_GT;
                OP_SLEI: a = AL_LE;
                OP_SGEI: a = AL_GE;
                OP_SNEI: a = AL_NE;
                default: a = AL_ADD;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/mcyc_regfile.sv
// Module mcyc_regfile
// General register file with two read ports and one write port.
// Reads are combinational and return zero unless rd_en is high;
// entry 0 always reads zero and never stores a write.
// Assumes the controller never asks for a read and a write together.
module mcyc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rdata1,
    output logic [W-1:0]  rdata2,
    input  logic          wr_en,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wdata
);

    logic [W-1:0] regs [NREG];

    // One storage process per entry; entry 0 stays constant zero.
    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        if (gi == 0) begin : g_zero
            always_ff @(posedge clk) begin
                regs[gi] <= '0;
            end
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[gi] <= '0;
                else if (wr_en && wa == AW'(gi))
                    regs[gi] <= wdata;
            end
        end
    end

    // Read ports, gated so that no read is visible outside decode.
    always_comb begin
        rdata1 = rd_en ? regs[ra1] : '0;
        rdata2 = rd_en ? regs[ra2] : '0;
    end

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en)); // R2

endmodule

// File: rtl/mcyc_alu.sv
// Module mcyc_alu
// Combinational ALU: add, subtract, bitwise logic, one-bit logical
// shifts of operand x, and signed compares that yield 0 or 1.
// Assumes the operation select is already decoded.
module mcyc_alu
    import mcyc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_e         op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] res
);

    logic signed [W-1:0] sx, sy;
    assign sx = x;
    assign sy = y;

    // Select the result for the requested operation.
    always_comb begin
        case (op)
            AL_ADD:  res = x + y;
            AL_SUB:  res = x - y;
            AL_AND:  res = x & y;
            AL_OR:   res = x | y;
            AL_XOR:  res = x ^ y;
            AL_SHL1: res = {x[W-2:0], 1'b0};
            AL_SHR1: res = {1'b0, x[W-1:1]};
            AL_LT:   res = W'(sx <  sy);
            AL_EQ:   res = W'(sx == sy);
            AL_GT:   res = W'(sx >  sy);
            AL_LE:   res = W'(sx <= sy);
            AL_GE:   res = W'(sx >= sy);
            AL_NE:   res = W'(sx != sy);
            default: res = x + y;
        endcase
    end

endmodule

// File: rtl/mcyc_fsm.sv
// Module mcyc_fsm
// Step controller: INIT, then FETCH/DECODE/EXEC for every instruction,
// MEM for loads and stores, WB for anything that writes a register,
// and a terminal HALT. Assumes cls is valid while the state is EXEC or MEM.
module mcyc_fsm
    import mcyc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cls_e   cls,
    output state_e state
);

    state_e nxt;

    // Next-step selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_INIT:   nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = ST_EXEC;
            ST_EXEC: begin
                case (cls)
                    CL_ALU_R, CL_ALU_I, CL_JALR: nxt = ST_WB;
                    CL_LOAD, CL_STORE:           nxt = ST_MEM;
                    CL_HALT:                     nxt = ST_HALT;
                    default:                     nxt = ST_FETCH;
                endcase
            end
            ST_MEM:    nxt = (cls == CL_LOAD) ? ST_WB : ST_FETCH;
            ST_WB:     nxt = ST_FETCH;
            ST_HALT:   nxt = ST_HALT;
            default:   nxt = ST_INIT;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= nxt;
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT)); // R9

endmodule

// File: rtl/mcyc_core.sv
// Module mcyc_core
// Top of the multicycle core: program counter, instruction register,
// operand latches (a, b), result latch (c), data address and store data
// latches, plus the register file, ALU and step controller.
// Assumes both memories return the addressed word one clock later.
module mcyc_core
    import mcyc_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG),
    localparam logic [RAW-1:0] LINK_REG = RAW'(NREG - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            halted
);

    state_e          state;
    cls_e            cls;
    alu_e            aop;
    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, c_q, mar_q, mdr_q;
    logic [XLEN-1:0] rd1, rd2, imm_x, alu_y, alu_res;
    logic            rf_rd, rf_wr;
    logic [RAW-1:0]  rf_wa;
    logic [XLEN-1:0] rf_wd;
    logic            br_take;

    assign cls   = classify(ir_q);
    assign aop   = alu_of(ir_q);
    assign imm_x = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
    assign alu_y = (cls == CL_ALU_R) ? b_q : imm_x;

    u_fsm_inst: begin end
    mcyc_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cls   (cls),
        .state (state)
    );

    mcyc_alu #(.W(XLEN)) u_alu (
        .op  (aop),
        .x   (a_q),
        .y   (alu_y),
        .res (alu_res)
    );

    // Register file ports: read in decode only, write in writeback only.
    always_comb begin
        rf_rd = (state == ST_DECODE);
        rf_wr = (state == ST_WB);
        if (cls == CL_JALR)       rf_wa = LINK_REG;
        else if (cls == CL_ALU_R) rf_wa = ir_q[15:11];
        else                      rf_wa = ir_q[20:16];
        rf_wd = (cls == CL_LOAD) ? dmem_rdata : c_q;
    end

    mcyc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rf_rd),
        .ra1    (imem_rdata[25:21]),
        .ra2    (imem_rdata[20:16]),
        .rdata1 (rd1),
        .rdata2 (rd2),
        .wr_en  (rf_wr),
        .wa     (rf_wa),
        .wdata  (rf_wd)
    );

    // Branch condition: opcode bit 0 selects the non-zero test.
    assign br_take = ir_q[26] ? (a_q != '0) : (a_q == '0);

    // Datapath registers updated by step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= {OP_NOP, 26'd0};
            a_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
            mar_q <= '0;
            mdr_q <= '0;
        end else begin
            case (state)
                ST_DECODE: begin
                    ir_q <= imem_rdata;
                    a_q  <= rd1;
                    b_q  <= rd2;
                    pc_q <= pc_q + 1'b1;
                end
                ST_EXEC: begin
                    c_q   <= alu_res;
                    mar_q <= a_q + imm_x;
                    mdr_q <= b_q;
                    case (cls)
                        CL_BRZ:  if (br_take) pc_q <= pc_q + imm_x;
                        CL_JR:   pc_q <= a_q;
                        CL_JALR: begin
                            c_q  <= pc_q;
                            pc_q <= a_q;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = mar_q;
    assign dmem_wdata = mdr_q;
    assign dmem_we    = (state == ST_MEM) && (cls == CL_STORE);
    assign halted     = (state == ST_HALT);

    AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && imem_rdata[25:21] == '0) |=> (a_q == '0)); // R1

    AST_PC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DECODE && state != ST_EXEC) |=> $stable(pc_q)); // R10

    AST_WE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (ir_q[31:26] == OP_SW)); // R6

    AST_HALT_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !dmem_we); // R9

endmodule

// File: tb/mcyc_core_bench.sv
// Directed bench: each task loads a program, runs it to halt, and checks
// the words the program stored into the bench-held data memory.
module mcyc_core_bench;
    import mcyc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, halted;

    logic [31:0] imem [256];
    logic [31:0] dmem [256];

    int n_chk = 0;
    int n_bad = 0;
    bit timed_out = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    mcyc_core u_mcyc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .halted     (halted)
    );

    // Synchronous memories: read data one clock after the address.
    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[7:0]];
        dmem_rdata <= dmem[dmem_addr[7:0]];
        if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
    end

    function automatic logic [31:0] ei(logic [5:0] op, int s, int d, int imm);
        return {op, 5'(s), 5'(d), 16'(imm)};
    endfunction

    function automatic logic [31:0] er(logic [5:0] fn, int s, int t, int d);
        return {OP_REG, 5'(s), 5'(t), 5'(d), 5'd0, fn};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i] = {OP_HALT, 26'd0};
            dmem[i] = '0;
        end
    endtask

    task automatic run();
        int cyc;
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) begin
            timed_out = 1'b1;
            chk("watchdog", 32'd0, 32'd1);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_mem();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 reset pc", imem_addr, 32'd0);
        chk("R9 reset halted", {31'd0, halted}, 32'd0);
        chk("R6 reset we", {31'd0, dmem_we}, 32'd0);
    endtask

    task automatic t_sum();
        clear_mem();
        imem[0] = ei(OP_ADDI, 0, 1, 0);
        imem[1] = ei(OP_ADDI, 0, 2, 0);
        imem[2] = er(FN_ADD, 1, 2, 1);
        imem[3] = ei(OP_ADDI, 2, 2, 1);
        imem[4] = ei(OP_SLEI, 2, 3, 100);
        imem[5] = ei(OP_BNEZ, 3, 0, -4);
        imem[6] = ei(OP_SW, 0, 1, 0);
        run();
        chk("R10 sum 0..100", dmem[0], 32'd5050);
    endtask

    task automatic t_alu();
        clear_mem();
        imem[0]  = ei(OP_ADDI, 0, 1, -7);
        imem[1]  = ei(OP_ADDI, 0, 2, 12);
        imem[2]  = er(FN_ADD, 1, 2, 3);
        imem[3]  = er(FN_SUB, 1, 2, 4);
        imem[4]  = er(FN_AND, 1, 2, 5);
        imem[5]  = er(FN_OR,  1, 2, 6);
        imem[6]  = er(FN_XOR, 1, 2, 7);
        imem[7]  = er(FN_SLLI, 1, 0, 8);
        imem[8]  = er(FN_SRLI, 1, 0, 9);
        for (int i = 0; i < 7; i++) imem[9 + i] = ei(OP_SW, 0, 3 + i, 10 + i);
        run();
        chk("R3 add", dmem[10], 32'd5);
        chk("R3 sub", dmem[11], 32'hFFFF_FFED);
        chk("R3 and", dmem[12], 32'h0000_0008);
        chk("R3 or",  dmem[13], 32'hFFFF_FFFD);
        chk("R3 xor", dmem[14], 32'hFFFF_FFF5);
        chk("R4 shl", dmem[15], 32'hFFFF_FFF2);
        chk("R4 shr", dmem[16], 32'h7FFF_FFFC);
    endtask

    task automatic t_cmp();
        clear_mem();
        imem[0] = ei(OP_ADDI, 0, 1, -7);
        imem[1] = ei(OP_SLTI, 1, 2, 5);
        imem[2] = ei(OP_SEQI, 1, 3, -7);
        imem[3] = ei(OP_SGTI, 1, 4, 5);
        imem[4] = ei(OP_SLEI, 1, 5, -7);
        imem[5] = ei(OP_SGEI, 1, 6, 5);
        imem[6] = ei(OP_SNEI, 1, 7, -7);
        imem[7] = ei(OP_SGTI, 1, 8, -8);
        for (int i = 0; i < 7; i++) imem[8 + i] = ei(OP_SW, 0, 2 + i, 20 + i);
        run();
        chk("R5 lt",  dmem[20], 32'd1);
        chk("R5 eq",  dmem[21], 32'd1);
        chk("R5 gt signed", dmem[22], 32'd0);
        chk("R5 le",  dmem[23], 32'd1);
        chk("R5 ge",  dmem[24], 32'd0);
        chk("R5 ne",  dmem[25], 32'd0);
        chk("R5 gt neg", dmem[26], 32'd1);
    endtask

    task automatic t_r0();
        clear_mem();
        imem[0] = ei(OP_ADDI, 0, 0, 55);
        imem[1] = er(FN_ADD, 0, 0, 5);
        imem[2] = ei(OP_SW, 0, 0, 30);
        imem[3] = ei(OP_SW, 0, 5, 31);
        imem[4] = {OP_REG, 20'd0, 6'h3A};
        imem[5] = ei(OP_SW, 0, 0, 32);
        run();
        dmem[33] = 32'd1;
        chk("R1 r0 write ignored", dmem[30], 32'd0);
        chk("R1 r0 as operand",    dmem[31], 32'd0);
        chk("R9 unknown function no effect", dmem[32], 32'd0);
    endtask

    task automatic t_mem();
        clear_mem();
        dmem[40] = 32'hAABB_CCDD;
        imem[0] = ei(OP_ADDI, 0, 1, 44);
        imem[1] = ei(OP_LW, 1, 2, -4);
        imem[2] = ei(OP_SW, 1, 2, 6);
        run();
        chk("R6 load/store", dmem[50], 32'hAABB_CCDD);
        chk("R6 source kept", dmem[40], 32'hAABB_CCDD);
    endtask

    task automatic t_branch();
        clear_mem();
        imem[0] = ei(OP_ADDI, 0, 1, 0);
        imem[1] = ei(OP_BEQZ, 1, 0, 1);
        imem[2] = ei(OP_ADDI, 0, 2, 99);
        imem[3] = ei(OP_BNEZ, 1, 0, 1);
        imem[4] = ei(OP_ADDI, 0, 3, 7);
        imem[5] = ei(OP_SW, 0, 2, 60);
        imem[6] = ei(OP_SW, 0, 3, 61);
        run();
        chk("R7 beqz taken skips", dmem[60], 32'd0);
        chk("R7 bnez not taken",   dmem[61], 32'd7);
    endtask

    task automatic t_jump();
        clear_mem();
        imem[0] = ei(OP_ADDI, 0, 1, 4);
        imem[1] = ei(OP_JALR, 1, 0, 0);
        imem[2] = ei(OP_ADDI, 0, 6, 1);
        imem[4] = ei(OP_SW, 0, 31, 70);
        imem[5] = ei(OP_ADDI, 0, 2, 8);
        imem[6] = ei(OP_JR, 2, 0, 0);
        imem[7] = ei(OP_ADDI, 0, 7, 3);
        imem[8] = ei(OP_SW, 0, 7, 71);
        imem[9] = {OP_NOP, 26'd0};
        imem[10] = ei(OP_SW, 0, 6, 72);
        run();
        chk("R8 link value", dmem[70], 32'd2);
        chk("R8 jr skips",   dmem[71], 32'd0);
        chk("R8 jalr skips", dmem[72], 32'd0);
    endtask

    task automatic t_halt();
        logic [31:0] pc0;
        bit saw_we;
        clear_mem();
        imem[0] = ei(OP_ADDI, 0, 1, 9);
        imem[1] = {OP_HALT, 26'd0};
        imem[2] = ei(OP_SW, 0, 1, 80);
        run();
        pc0 = imem_addr;
        saw_we = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (dmem_we) saw_we = 1'b1;
        end
        chk("R9 halted held", {31'd0, halted}, 32'd1);
        chk("R9 pc frozen", imem_addr, pc0);
        chk("R9 no store after halt", {31'd0, saw_we}, 32'd0);
        chk("R9 memory untouched", dmem[80], 32'd0);
    endtask

    initial begin
        t_reset();
        t_sum();
        t_alu();
        t_cmp();
        t_r0();
        t_mem();
        t_branch();
        t_jump();
        t_halt();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule